// File: doc/BRIEF.md
# Tick-Driven Programmable Timer

A single timer cell for control logic. It offers three behaviours: a fixed-width pulse that cannot be retriggered, an on-delay that only passes a level which stays high for the whole preset time, and an off-delay that holds a level for the preset time after it goes low. Time is counted in ticks: the elapsed count moves only on clock cycles where the tick-enable input is high. A slow strobe on that input turns the clock into a millisecond or second time base.

The preset is taken as a tick count. It is captured when an interval starts, so changing it during an interval has no effect on that interval. The output `q` and the elapsed count are registered and follow the inputs by one clock. The behaviour is chosen either by a static input that is held constant after reset, or by a parameter that fixes it at build time.

Top module: `ptimer_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with `trig_in` low, `q` is 0 and `elapsed` is 0.
- R2: In pulse behaviour (`mode_sel` = 0), a rising edge of `trig_in` sets `q` on the next clock with `elapsed` = 0. `q` then stays high while `elapsed` counts ticks, and it falls in the same clock in which `elapsed` reaches the preset.
- R3: In pulse behaviour, further rising edges of `trig_in` during a pulse neither restart nor lengthen it. After the pulse, `elapsed` stays at the preset while `trig_in` is high, and it returns to 0 one clock after `trig_in` is sampled low.
- R4: In on-delay behaviour (`mode_sel` = 1), with `trig_in` held high, `elapsed` counts ticks from 0 and `q` rises in the clock in which `elapsed` reaches the preset. `elapsed` holds at the preset while `q` is high. Both clear one clock after `trig_in` is sampled low.
- R5: In on-delay behaviour, if `trig_in` is low before the preset is reached, `q` never rises for that high period and `elapsed` returns to 0. This also applies when the low input and the final tick arrive in the same cycle.
- R6: In off-delay behaviour (`mode_sel` = 2), `q` rises one clock after `trig_in` is sampled high, with `elapsed` = 0. Once `trig_in` is low, `q` stays high while `elapsed` counts ticks and falls when `elapsed` reaches the preset. `elapsed` then holds at the preset until `trig_in` is high again.
- R7: In off-delay behaviour, if `trig_in` returns high while the hold-off is running, `q` stays high and `elapsed` returns to 0. This also applies when the high input and the final tick arrive in the same cycle.
- R8: `elapsed` advances only in clock cycles where `tick` is high. In every other cycle it keeps its value or returns to 0.
- R9: The preset is captured when an interval starts (pulse start, on-delay start, or off-delay start on the falling input). Later changes of `preset` do not change the length of that interval.
- R10: With a preset of 0, in on-delay and off-delay behaviour `q` equals `trig_in` delayed by one clock, and `elapsed` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable; one tick of elapsed time per high cycle |
| trig_in | input | 1 | Boolean timer input |
| preset | input | CNT_W | Interval length in ticks |
| mode_sel | input | 2 | Behaviour: 0 pulse, 1 on-delay, 2 off-delay (3 acts as pulse); used when USE_MODE_PIN = 1 |
| q | output | 1 | Timer output |
| elapsed | output | CNT_W | Ticks elapsed in the current or last interval |

## Verification
The final tick of an interval and a reversal of `trig_in` can fall in the same clock. For the on-delay the reversal is a fall that cancels the delay. For the off-delay it is a rise that re-arms the hold. The bench provokes this by letting `elapsed` reach one below the preset and then, in the very next cycle, driving `tick` high together with the opposite input level. It judges the result on the following clock: the input reversal must win, so the on-delay output stays low with `elapsed` cleared, and the off-delay output stays high with `elapsed` cleared.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

   typedef enum logic [1:0] {
      MODE_PULSE   = 2'd0,
      MODE_ON_DLY  = 2'd1,
      MODE_OFF_DLY = 2'd2
   } tmr_mode_e;

   // Phases shared by all behaviours; HELD is used only by the off-delay.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2,
      ST_HELD = 2'd3
   } tmr_state_e;

   typedef struct packed {
      logic start;   // capture preset, zero the count
      logic clear;   // zero the count
      logic step;    // advance the count by one
   } cnt_cmd_t;

endpackage

// File: rtl/ptimer_edge.sv
module ptimer_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_d;

   always_ff @(posedge clk) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign rise = level & ~level_d;
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CNT_W-1:0]      preset,
   input  ptimer_pkg::cnt_cmd_t  cmd,
   output logic [CNT_W-1:0]      et,
   output logic                  last,
   output logic                  preset_zero
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] pt_q;
   logic [EXT_W-1:0] et_inc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         et   <= '0;
         pt_q <= '0;
      end else if (cmd.start) begin
         et   <= '0;
         pt_q <= preset;
      end else if (cmd.clear) begin
         et   <= '0;
      end else if (cmd.step) begin
         et   <= et_inc[CNT_W-1:0];
      end
   end

   assign et_inc      = {1'b0, et} + EXT_W'(1);
   assign last        = (et_inc == {1'b0, pt_q});
   assign preset_zero = (preset == '0);
endmodule

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
   import ptimer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       in_lvl,
   input  logic       rise,
   input  logic       tick,
   input  logic       last,
   input  logic       preset_zero,
   output cnt_cmd_t   cmd,
   output logic       q
);
   tmr_state_e st, st_nxt;
   logic       q_nxt;

   always_comb begin
      st_nxt = st;
      q_nxt  = q;
      cmd    = '0;
      case (mode)
         MODE_ON_DLY: begin
            case (st)
               ST_IDLE: begin
                  q_nxt = 1'b0;
                  if (in_lvl) begin
                     cmd.start = 1'b1;
                     if (preset_zero) begin
                        q_nxt  = 1'b1;
                        st_nxt = ST_DONE;
                     end else begin
                        st_nxt = ST_RUN;
                     end
                  end
               end
               ST_RUN: begin
                  q_nxt = 1'b0;
                  if (!in_lvl) begin            // cancel beats expiry
                     cmd.clear = 1'b1;
                     st_nxt    = ST_IDLE;
                  end else if (tick) begin
                     cmd.step = 1'b1;
                     if (last) begin
                        q_nxt  = 1'b1;
                        st_nxt = ST_DONE;
                     end
                  end
               end
               default: begin
                  q_nxt = 1'b1;
                  if (!in_lvl) begin
                     q_nxt     = 1'b0;
                     cmd.clear = 1'b1;
                     st_nxt    = ST_IDLE;
                  end
               end
            endcase
         end
         MODE_OFF_DLY: begin
            case (st)
               ST_HELD: begin
                  q_nxt = 1'b1;
                  if (!in_lvl) begin
                     cmd.start = 1'b1;
                     if (preset_zero) begin
                        q_nxt  = 1'b0;
                        st_nxt = ST_IDLE;
                     end else begin
                        st_nxt = ST_RUN;
                     end
                  end
               end
               ST_RUN: begin
                  q_nxt = 1'b1;
                  if (in_lvl) begin             // re-arm beats expiry
                     cmd.clear = 1'b1;
                     st_nxt    = ST_HELD;
                  end else if (tick) begin
                     cmd.step = 1'b1;
                     if (last) begin
                        q_nxt  = 1'b0;
                        st_nxt = ST_IDLE;
                     end
                  end
               end
               default: begin
                  q_nxt = 1'b0;
                  if (in_lvl) begin
                     q_nxt     = 1'b1;
                     cmd.clear = 1'b1;
                     st_nxt    = ST_HELD;
                  end
               end
            endcase
         end
         default: begin                          // pulse
            case (st)
               ST_RUN: begin
                  q_nxt = 1'b1;
                  if (tick) begin
                     cmd.step = 1'b1;
                     if (last) begin
                        q_nxt  = 1'b0;
                        st_nxt = ST_DONE;
                     end
                  end
               end
               ST_DONE: begin
                  q_nxt = 1'b0;
                  if (!in_lvl) begin
                     cmd.clear = 1'b1;
                     st_nxt    = ST_IDLE;
                  end
               end
               default: begin
                  q_nxt = 1'b0;
                  if (rise) begin
                     cmd.start = 1'b1;
                     if (preset_zero) begin
                        st_nxt = ST_DONE;
                     end else begin
                        q_nxt  = 1'b1;
                        st_nxt = ST_RUN;
                     end
                  end
               end
            endcase
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         q  <= 1'b0;
      end else begin
         st <= st_nxt;
         q  <= q_nxt;
      end
   end
endmodule

// File: rtl/ptimer_unit.sv
module ptimer_unit
   import ptimer_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter bit USE_MODE_PIN = 1'b1,
   parameter int FIXED_MODE   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             trig_in,
   input  logic [CNT_W-1:0] preset,
   input  logic [1:0]       mode_sel,
   output logic             q,
   output logic [CNT_W-1:0] elapsed
);
   localparam logic [1:0] FIXED_CODE = FIXED_MODE[1:0];

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("ptimer_unit: CNT_W must be within 2..32");
   end
   if (FIXED_MODE < 0 || FIXED_MODE > 2) begin : g_bad_mode
      $error("ptimer_unit: FIXED_MODE must be 0, 1 or 2");
   end

   logic [1:0] mode_eff;

   if (USE_MODE_PIN) begin : g_mode_pin
      assign mode_eff = mode_sel;
   end else begin : g_mode_fixed
      logic unused_mode;
      assign unused_mode = ^mode_sel;
      assign mode_eff    = FIXED_CODE;
   end

   logic     rise, last, preset_zero;
   cnt_cmd_t cmd;

   ptimer_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (trig_in),
      .rise  (rise)
   );

   ptimer_count #(.CNT_W(CNT_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .preset      (preset),
      .cmd         (cmd),
      .et          (elapsed),
      .last        (last),
      .preset_zero (preset_zero)
   );

   ptimer_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode_eff),
      .in_lvl      (trig_in),
      .rise        (rise),
      .tick        (tick),
      .last        (last),
      .preset_zero (preset_zero),
      .cmd         (cmd),
      .q           (q)
   );
endmodule

// File: rtl/ptimer_unit_chk.sv
module ptimer_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             trig_in,
   input logic [1:0]       mode,
   input logic             q,
   input logic [CNT_W-1:0] elapsed
);
   // R8: without a tick the count never advances
   assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (elapsed == $past(elapsed) || elapsed == '0));

   // R8: the count moves by single steps or returns to zero
   assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (elapsed != $past(elapsed)) |-> (elapsed == CNT_W'($past(elapsed) + 1'b1) || elapsed == '0));

   // R5: a low input forbids the on-delay output on the next clock
   assert_ondly_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && !trig_in) |=> !q);

   // R4: the on-delay count is frozen while the output is high and input stays high
   assert_ondly_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && q && trig_in) |=> (q && elapsed == $past(elapsed)));

   // R6: a high input raises the off-delay output on the next clock
   assert_offdly_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && trig_in) |=> q);

   // R3: after a pulse the count stays put while the input stays high
   assert_pulse_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !q && elapsed != '0 && trig_in) |=> (!q && elapsed == $past(elapsed)));
endmodule

bind ptimer_unit ptimer_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .trig_in (trig_in),
   .mode    (mode_eff),
   .q       (q),
   .elapsed (elapsed)
);

// File: tb/ptimer_unit_bench.sv
`timescale 1ns/1ps
module ptimer_unit_bench;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic             trig_in = 1'b0;
   logic [CNT_W-1:0] preset = '0;
   logic [1:0]       mode_sel = 2'd0;
   logic             q;
   logic [CNT_W-1:0] elapsed;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   typedef struct {
      int    at;
      bit    q;
      int    et;
      string tag;
   } exp_t;

   exp_t eq[$];

   ptimer_unit #(.CNT_W(CNT_W)) u_ptimer_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .trig_in  (trig_in),
      .preset   (preset),
      .mode_sel (mode_sel),
      .q        (q),
      .elapsed  (elapsed)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare the outputs against queued expectations, away from the edge.
   always @(negedge clk) begin
      exp_t e;
      while (eq.size() > 0 && eq[0].at <= cyc) begin
         e = eq.pop_front();
         checks++;
         if (e.at != cyc || q !== e.q || elapsed !== CNT_W'(e.et)) begin
            failures++;
            $display("FAIL %s cycle %0d: q=%0b elapsed=%0d expected q=%0b elapsed=%0d",
                     e.tag, cyc, q, elapsed, e.q, e.et);
         end
      end
   end

   task automatic drv(input bit i, input bit t);
      @(negedge clk);
      trig_in = i;
      tick    = t;
   endtask

   task automatic want(input bit eq_q, input int eq_et, input string tag);
      eq.push_back('{cyc + 1, eq_q, eq_et, tag});
   endtask

   task automatic do_reset(input logic [1:0] m, input int pt);
      @(negedge clk);
      rst_n    = 1'b0;
      trig_in  = 1'b0;
      tick     = 1'b0;
      mode_sel = m;
      preset   = CNT_W'(pt);
      repeat (2) @(negedge clk);
      checks++;
      if (q !== 1'b0 || elapsed !== '0) begin
         failures++;
         $display("FAIL R1 in reset: q=%0b elapsed=%0d expected q=0 elapsed=0", q, elapsed);
      end
      rst_n = 1'b1;
      want(1'b0, 0, "R1");
   endtask

   initial begin
      // ---------------- pulse, preset 4 ----------------
      do_reset(2'd0, 4);
      drv(1, 1); want(1, 0, "R2");
      drv(0, 1); want(1, 1, "R2");
      drv(1, 1); want(1, 2, "R3");           // edge during pulse ignored
      drv(1, 0); want(1, 2, "R8");           // no tick, no advance
      drv(0, 1); want(1, 3, "R2");
      drv(1, 1); want(0, 4, "R2");           // expiry, edge ignored
      drv(1, 1); want(0, 4, "R3");
      drv(1, 1); want(0, 4, "R3");
      drv(0, 1); want(0, 0, "R3");
      drv(0, 1); want(0, 0, "R2");
      drv(1, 0); want(1, 0, "R2");           // new pulse
      drv(1, 1); want(1, 1, "R9");
      preset = CNT_W'(2);                    // after capture
      drv(1, 1); want(1, 2, "R9");
      drv(1, 1); want(1, 3, "R9");
      drv(1, 1); want(0, 4, "R9");
      drv(0, 0); want(0, 0, "R3");
      drv(0, 0); want(0, 0, "R3");

      // ---------------- on-delay, preset 3 ----------------
      do_reset(2'd1, 3);
      drv(1, 0); want(0, 0, "R5");
      drv(1, 1); want(0, 1, "R5");
      drv(0, 1); want(0, 0, "R5");           // short pulse cancelled
      drv(0, 1); want(0, 0, "R5");
      drv(1, 1); want(0, 0, "R4");
      drv(1, 1); want(0, 1, "R4");
      drv(1, 1); want(0, 2, "R4");
      drv(1, 1); want(1, 3, "R4");
      drv(1, 1); want(1, 3, "R4");
      drv(1, 0); want(1, 3, "R4");
      drv(0, 1); want(0, 0, "R4");
      drv(1, 1); want(0, 0, "R5");
      drv(1, 1); want(0, 1, "R5");
      drv(1, 1); want(0, 2, "R5");
      drv(0, 1); want(0, 0, "R5");           // fall collides with last tick
      drv(0, 0); want(0, 0, "R5");
      preset = '0;
      drv(1, 1); want(1, 0, "R10");
      drv(1, 1); want(1, 0, "R10");
      drv(0, 1); want(0, 0, "R10");

      // ---------------- off-delay, preset 3 ----------------
      do_reset(2'd2, 3);
      drv(1, 1); want(1, 0, "R6");
      drv(0, 1); want(1, 0, "R6");
      drv(0, 1); want(1, 1, "R6");
      drv(0, 0); want(1, 1, "R8");
      drv(0, 1); want(1, 2, "R6");
      drv(0, 1); want(0, 3, "R6");
      drv(0, 1); want(0, 3, "R6");
      drv(1, 1); want(1, 0, "R6");
      drv(0, 1); want(1, 0, "R7");
      drv(0, 1); want(1, 1, "R7");
      drv(0, 1); want(1, 2, "R7");
      drv(1, 1); want(1, 0, "R7");           // rise collides with last tick
      drv(1, 1); want(1, 0, "R7");
      drv(0, 1); want(1, 0, "R9");
      drv(0, 1); want(1, 1, "R9");
      preset = CNT_W'(10);                   // after capture
      drv(0, 1); want(1, 2, "R9");
      drv(0, 1); want(0, 3, "R9");
      preset = '0;
      drv(1, 1); want(1, 0, "R10");
      drv(0, 1); want(0, 0, "R10");
      drv(0, 0); want(0, 0, "R10");

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule